// File: doc/BRIEF.md
# Slot-Based Hardware Thread Scheduler

This block decides, once per clock cycle, which of up to eight hardware threads may issue its next instruction into a shared pipeline. Two configuration tables drive the decision.

The slot table is a ring of small codes. A code can leave its slot out of the ring. It can give the slot to one thread, which then gets a fixed share of issue cycles. It can also hand the slot to the pool of soft threads. The mode table holds, for every thread, whether it is hard or soft and whether it is running or asleep. A slot that belongs to the pool, or whose owning thread is asleep, is passed to a separate round-robin over the running soft threads. Hard threads therefore keep a constant issue rate, and soft threads soak up every cycle that would otherwise go to waste.

The result leaves the block as a valid-only stream: `issue_valid` with `issue_tid`. There is no ready signal. The consumer must take every cycle, and a cycle with `issue_valid` low is a bubble with nothing to hold. Writes to the tables are guarded by the identity and privilege of the thread that performs them. Wake requests from hardware events can bring sleeping threads back to running.

Top module: `thread_issue_sched`

## Requirements
- R1: Slot table layout and codes:
  - Slot i sits in bits 4i+3:4i, so slot 0 is in bits 3:0.
  - Code 4'hE hands the slot to the soft pool.
  - A code below NUM_THREADS dedicates the slot to that thread ID.
  - Any other code, including 4'hF, disables the slot.
- R2: Disabled slots are skipped. The enabled slots are visited cyclically, one per clock cycle, and the walk starts at slot 0 after reset.
- R3: When a dedicated slot's thread is running (mode 2'b00 or 2'b10), that thread is issued.
- R4: A slot marked for the pool, or dedicated to a sleeping thread, is delegated. The cycle goes to the first running soft thread (mode 2'b10) after the last one the rotation granted. After reset the search starts at thread 0.
- R5: The soft rotation moves only when it grants a delegated cycle. A thread issued through its own dedicated slot does not move it.
- R6: `issue_valid` is 0 in two cases: a delegated cycle finds no running soft thread, or every slot is disabled.
- R7: Mode table layout and codes:
  - Thread t has a 2-bit field at bits 2t+1:2t.
  - The codes are 00 running hard, 01 sleeping hard, 10 running soft and 11 sleeping soft.
  - A supervisor write replaces every field.
  - A non-supervisor write changes only the writer's own field.
- R8: A slot table write takes effect only when `cfg_src_super` is 1.
- R9: A wake request bit clears bit 0 of that thread's mode field. A sleeping thread becomes running and keeps its hard or soft kind. A running thread is unaffected. An accepted mode write to the same field in the same cycle takes precedence.
- R10: Reset state:
  - All slots are disabled.
  - All threads are sleeping soft.
  - `issue_valid` is 0.
- R11: Table writes and wake requests take effect on the next clock edge. The issue decision made in a cycle appears on the outputs after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_src_tid | input | 3 | Thread ID of the writer of a table update |
| cfg_src_super | input | 1 | Writer holds supervisory privilege |
| cfg_slot_we | input | 1 | Slot table write strobe |
| cfg_slot_data | input | 32 | New slot table contents |
| cfg_mode_we | input | 1 | Mode table write strobe |
| cfg_mode_data | input | 16 | New mode table contents |
| wake_req | input | 8 | Per-thread wake pulse from hardware events |
| issue_valid | output | 1 | A thread is issued this cycle |
| issue_tid | output | 3 | ID of the issued thread |

## Verification
The assertions assume the following about the inputs:
- `cfg_src_tid` names an existing thread.
- Write strobes are single-cycle pulses.
- A wake pulse does not coincide with a mode write; the wake property excludes that case.

The stimulus changes inputs only on falling edges, keeping them clear of the sampling edge. It issues each table update and each wake as a single pulse, always from a valid writer ID. Every scenario starts from reset, so the positions of the slot walk and the soft rotation are known exactly. The expected issue order for each scenario is worked out by hand from the requirements.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int SLOT_CODE_W = 4;
  localparam int MODE_W      = 2;

  localparam logic [SLOT_CODE_W-1:0] SLOT_CODE_OFF    = 4'hF;
  localparam logic [SLOT_CODE_W-1:0] SLOT_CODE_SHARED = 4'hE;

  typedef enum logic [MODE_W-1:0] {
    MODE_HARD_RUN   = 2'b00,
    MODE_HARD_SLEEP = 2'b01,
    MODE_SOFT_RUN   = 2'b10,
    MODE_SOFT_SLEEP = 2'b11
  } thr_mode_e;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_POOL  = 2'd1,
    SLOT_OWNED = 2'd2
  } slot_kind_e;

  // Decode a slot code: pool, dedicated to an existing thread, or skipped.
  function automatic slot_kind_e classify_slot(input logic [SLOT_CODE_W-1:0] code,
                                               input int n_threads);
    if (code == SLOT_CODE_SHARED) return SLOT_POOL;
    if (int'(code) < n_threads)   return SLOT_OWNED;
    return SLOT_IDLE;
  endfunction

endpackage

// File: rtl/sched_cfg_regs.sv
// Holds the slot and mode tables; applies privilege checks and wake pulses.
module sched_cfg_regs
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 8,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int TABLE_W    = NUM_SLOTS * SLOT_CODE_W,
  localparam int MODE_TBL_W = NUM_THREADS * MODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TID_W-1:0]      cfg_src_tid,
  input  logic                  cfg_src_super,
  input  logic                  cfg_slot_we,
  input  logic [TABLE_W-1:0]    cfg_slot_data,
  input  logic                  cfg_mode_we,
  input  logic [MODE_TBL_W-1:0] cfg_mode_data,
  input  logic [NUM_THREADS-1:0] wake_req,
  output logic [TABLE_W-1:0]    slot_tbl_q,
  output logic [MODE_TBL_W-1:0] mode_tbl_q
);

  localparam logic [TABLE_W-1:0]    SLOT_RST = {NUM_SLOTS{SLOT_CODE_OFF}};
  localparam logic [MODE_TBL_W-1:0] MODE_RST = {NUM_THREADS{2'b11}};

  logic [MODE_TBL_W-1:0] mode_tbl_d;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_field
    logic             own_write;
    logic [MODE_W-1:0] field_d;

    assign own_write = cfg_mode_we &&
                       (cfg_src_super || (cfg_src_tid == TID_W'(t)));

    always_comb begin
      field_d = mode_tbl_q[t*MODE_W +: MODE_W];
      if (wake_req[t]) field_d[0] = 1'b0;
      if (own_write)   field_d = cfg_mode_data[t*MODE_W +: MODE_W];
    end

    assign mode_tbl_d[t*MODE_W +: MODE_W] = field_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_tbl_q <= SLOT_RST;
      mode_tbl_q <= MODE_RST;
    end else begin
      mode_tbl_q <= mode_tbl_d;
      if (cfg_slot_we && cfg_src_super) slot_tbl_q <= cfg_slot_data;
    end
  end

endmodule

// File: rtl/sched_slot_walker.sv
// Walks the enabled slots cyclically, one per cycle, skipping disabled ones.
module sched_slot_walker
  import sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int NUM_THREADS = 8,
  localparam int IDX_W      = $clog2(NUM_SLOTS),
  localparam int TABLE_W    = NUM_SLOTS * SLOT_CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TABLE_W-1:0]     slot_tbl,
  output logic                   pick_valid,
  output logic [SLOT_CODE_W-1:0] pick_code
);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    int idx;
    pick_valid = 1'b0;
    pick_code  = SLOT_CODE_OFF;
    ptr_d      = ptr_q;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= NUM_SLOTS) idx = idx - NUM_SLOTS;
      if (!pick_valid &&
          classify_slot(slot_tbl[idx*SLOT_CODE_W +: SLOT_CODE_W], NUM_THREADS) != SLOT_IDLE) begin
        pick_valid = 1'b1;
        pick_code  = slot_tbl[idx*SLOT_CODE_W +: SLOT_CODE_W];
        ptr_d      = (idx == NUM_SLOTS - 1) ? '0 : IDX_W'(idx + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/sched_soft_rr.sv
// Round-robin over running soft threads; remembers the last thread it granted.
module sched_soft_rr #(
  parameter int NUM_THREADS = 8,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] soft_run,
  input  logic                   grant_take,
  output logic                   any_run,
  output logic [TID_W-1:0]       grant_tid
);

  logic [TID_W-1:0] last_q;

  always_comb begin
    int idx;
    any_run   = 1'b0;
    grant_tid = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      idx = int'(last_q) + k;
      if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
      if (!any_run && soft_run[idx]) begin
        any_run   = 1'b1;
        grant_tid = TID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     last_q <= TID_W'(NUM_THREADS - 1);
    else if (grant_take && any_run) last_q <= grant_tid;
  end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 8,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int TABLE_W    = NUM_SLOTS * SLOT_CODE_W,
  localparam int MODE_TBL_W = NUM_THREADS * MODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TID_W-1:0]       cfg_src_tid,
  input  logic                   cfg_src_super,
  input  logic                   cfg_slot_we,
  input  logic [TABLE_W-1:0]     cfg_slot_data,
  input  logic                   cfg_mode_we,
  input  logic [MODE_TBL_W-1:0]  cfg_mode_data,
  input  logic [NUM_THREADS-1:0] wake_req,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid
);

  logic [TABLE_W-1:0]     slot_tbl_q;
  logic [MODE_TBL_W-1:0]  mode_tbl_q;
  logic                   pick_valid;
  logic [SLOT_CODE_W-1:0] pick_code;
  logic [NUM_THREADS-1:0] thr_run, thr_soft_run;
  logic                   rr_any, delegate;
  logic [TID_W-1:0]       rr_tid, owner_tid;
  logic                   valid_d;
  logic [TID_W-1:0]       tid_d;
  slot_kind_e             pick_kind;

  sched_cfg_regs #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_tid(cfg_src_tid), .cfg_src_super(cfg_src_super),
    .cfg_slot_we(cfg_slot_we), .cfg_slot_data(cfg_slot_data),
    .cfg_mode_we(cfg_mode_we), .cfg_mode_data(cfg_mode_data),
    .wake_req(wake_req),
    .slot_tbl_q(slot_tbl_q), .mode_tbl_q(mode_tbl_q)
  );

  sched_slot_walker #(.NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS)) u_walk (
    .clk(clk), .rst_n(rst_n), .slot_tbl(slot_tbl_q),
    .pick_valid(pick_valid), .pick_code(pick_code)
  );

  sched_soft_rr #(.NUM_THREADS(NUM_THREADS)) u_rr (
    .clk(clk), .rst_n(rst_n), .soft_run(thr_soft_run), .grant_take(delegate),
    .any_run(rr_any), .grant_tid(rr_tid)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_state
    assign thr_run[t]      = ~mode_tbl_q[t*MODE_W];
    assign thr_soft_run[t] = (mode_tbl_q[t*MODE_W +: MODE_W] == MODE_SOFT_RUN);
  end

  assign pick_kind = classify_slot(pick_code, NUM_THREADS);
  assign owner_tid = pick_code[TID_W-1:0];

  always_comb begin
    valid_d  = 1'b0;
    tid_d    = '0;
    delegate = 1'b0;
    if (pick_valid) begin
      if (pick_kind == SLOT_OWNED && thr_run[owner_tid]) begin
        valid_d = 1'b1;
        tid_d   = owner_tid;
      end else begin
        delegate = 1'b1;
        valid_d  = rr_any;
        tid_d    = rr_tid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
    end else begin
      issue_valid <= valid_d;
      issue_tid   <= tid_d;
    end
  end

endmodule

// File: rtl/thread_issue_sched_chk.sv
module thread_issue_sched_chk
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 8,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int TABLE_W    = NUM_SLOTS * SLOT_CODE_W,
  localparam int MODE_TBL_W = NUM_THREADS * MODE_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_src_super,
  input logic                   cfg_slot_we,
  input logic                   cfg_mode_we,
  input logic [NUM_THREADS-1:0] wake_req,
  input logic                   issue_valid,
  input logic [TID_W-1:0]       issue_tid,
  input logic [TABLE_W-1:0]     slot_tbl_q,
  input logic [MODE_TBL_W-1:0]  mode_tbl_q
);

  logic [MODE_TBL_W-1:0] mode_seen_q, wake_bits_d, wake_bits_q;
  logic                  all_idle_d, all_idle_q;

  always_comb begin
    all_idle_d  = 1'b1;
    wake_bits_d = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (classify_slot(slot_tbl_q[s*SLOT_CODE_W +: SLOT_CODE_W], NUM_THREADS) != SLOT_IDLE)
        all_idle_d = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++)
      wake_bits_d[t*MODE_W] = wake_req[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_seen_q <= '1;
      wake_bits_q <= '0;
      all_idle_q  <= 1'b1;
    end else begin
      mode_seen_q <= mode_tbl_q;
      wake_bits_q <= wake_bits_d;
      all_idle_q  <= all_idle_d;
    end
  end

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !issue_valid);

  assert_issue_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (mode_seen_q[{issue_tid, 1'b0}] == 1'b0));

  assert_slot_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slot_we && !cfg_src_super) |=> $stable(slot_tbl_q));

  assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wake_req) && !cfg_mode_we) |=> ((mode_tbl_q & wake_bits_q) == '0));

  assert_idle_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    all_idle_q |-> !issue_valid);

endmodule

bind thread_issue_sched thread_issue_sched_chk #(
  .NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_src_super(cfg_src_super),
  .cfg_slot_we(cfg_slot_we), .cfg_mode_we(cfg_mode_we), .wake_req(wake_req),
  .issue_valid(issue_valid), .issue_tid(issue_tid),
  .slot_tbl_q(slot_tbl_q), .mode_tbl_q(mode_tbl_q)
);

// File: tb/thread_issue_sched_tb.sv
module thread_issue_sched_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_src_tid = '0;
  logic        cfg_src_super = 1'b0;
  logic        cfg_slot_we = 1'b0;
  logic [31:0] cfg_slot_data = '0;
  logic        cfg_mode_we = 1'b0;
  logic [15:0] cfg_mode_data = '0;
  logic [7:0]  wake_req = '0;
  logic        issue_valid;
  logic [2:0]  issue_tid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bit    exp_v_q[$];
  int    exp_t_q[$];
  string exp_r_q[$];

  always #(CLK_P/2) clk = ~clk;

  thread_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_src_tid(cfg_src_tid), .cfg_src_super(cfg_src_super),
    .cfg_slot_we(cfg_slot_we), .cfg_slot_data(cfg_slot_data),
    .cfg_mode_we(cfg_mode_we), .cfg_mode_data(cfg_mode_data),
    .wake_req(wake_req), .issue_valid(issue_valid), .issue_tid(issue_tid)
  );

  // Sequence packed as nibbles, first item most significant; 4'hF means a bubble.
  task automatic expect_seq(input string req, input int n, input logic [63:0] seq);
    logic [3:0] c;
    for (int i = 0; i < n; i++) begin
      c = seq[(n-1-i)*4 +: 4];
      exp_v_q.push_back(c != 4'hF);
      exp_t_q.push_back(int'(c));
      exp_r_q.push_back(req);
    end
  endtask

  task automatic wait_drain();
    while (exp_v_q.size() != 0) @(negedge clk);
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic write_slots(input logic [31:0] d, input int src, input bit sup);
    cfg_slot_we = 1'b1; cfg_slot_data = d; cfg_src_tid = 3'(src); cfg_src_super = sup;
    @(negedge clk);
    cfg_slot_we = 1'b0; cfg_src_super = 1'b0;
  endtask

  task automatic write_modes(input logic [15:0] d, input int src, input bit sup);
    cfg_mode_we = 1'b1; cfg_mode_data = d; cfg_src_tid = 3'(src); cfg_src_super = sup;
    @(negedge clk);
    cfg_mode_we = 1'b0; cfg_src_super = 1'b0;
  endtask

  task automatic pulse_wake(input logic [7:0] w);
    wake_req = w;
    @(negedge clk);
    wake_req = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (issue_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: issue_valid=%0b expected 0", issue_valid);
    end
  endtask

  task automatic start_scenario(input logic [15:0] modes, input logic [31:0] slots);
    do_reset();
    write_modes(modes, 0, 1'b1);
    write_slots(slots, 0, 1'b1);
  endtask

  // Scoreboard monitor: samples a quarter period after each rising edge.
  initial begin
    bit v; int t; string r;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_v_q.size() != 0) begin
        v = exp_v_q.pop_front(); t = exp_t_q.pop_front(); r = exp_r_q.pop_front();
        n_checks++;
        if (v ? (issue_valid !== 1'b1 || int'(issue_tid) != t) : (issue_valid !== 1'b0)) begin
          n_fail++;
          $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                   r, issue_valid, issue_tid, v, t);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 / R6: after reset every slot is off, so only bubbles appear.
    do_reset();
    expect_seq("R6 all slots off", 3, 64'hFFF);
    wait_drain();

    // R1 R2 R3 R4: one hard thread at 1 in 4, sleeping dedicated slot delegated.
    start_scenario(16'hFFA4, 32'hFFFF01E1);
    expect_seq("R4 hard plus two soft", 8, 64'h23203230);
    wait_drain();

    // R3: both hard threads running, pool cycles rotate over three soft threads.
    start_scenario(16'hFEA0, 32'hFFFF01E1);
    expect_seq("R3 two hard threads", 12, 64'h121013101410);
    wait_drain();

    // R2: scattered enabled slots among disabled ones.
    start_scenario(16'hEB7C, 32'hF3FEFF0F);
    expect_seq("R2 skip disabled", 7, 64'h0560560);
    wait_drain();
    expect_seq("R9 wake sleeping hard", 4, 64'h5306);
    pulse_wake(8'h08);
    wait_drain();

    // R5: a soft thread issued from its own slot does not move the rotation.
    start_scenario(16'hFFAF, 32'hFFFFFFE2);
    expect_seq("R5 rotation unmoved", 6, 64'h222322);
    wait_drain();
    expect_seq("R9 wake sleeping soft", 4, 64'h2324);
    pulse_wake(8'h10);
    wait_drain();

    // R6: no running soft thread gives bubbles; then R9 wakes the hard owner.
    start_scenario(16'hFFF7, 32'hFFFFFFE1);
    expect_seq("R6 no soft thread", 4, 64'hFFFF);
    wait_drain();
    expect_seq("R9 wake hard owner", 5, 64'hFF1F1);
    pulse_wake(8'h02);
    wait_drain();

    // R7 R8: privilege checks on both tables.
    start_scenario(16'hFFF2, 32'hFFFFFFF1);
    expect_seq("R3 dedicated running", 3, 64'h111);
    wait_drain();
    expect_seq("R8 unprivileged slot write", 4, 64'h1111);
    write_slots(32'hFFFFFFFE, 1, 1'b0);
    wait_drain();
    expect_seq("R7 foreign field untouched", 4, 64'h1111);
    write_modes(16'hFFF6, 0, 1'b0);
    wait_drain();
    expect_seq("R7 own field written", 4, 64'h1000);
    write_modes(16'h0005, 1, 1'b0);
    wait_drain();
    expect_seq("R11 wake one edge later", 3, 64'h011);
    pulse_wake(8'h02);
    wait_drain();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule